// File: doc/BRIEF.md
# Packed 52-bit Multiply-Accumulate Unit

This block is a pipelined SIMD datapath. It takes three vectors made of 64-bit lanes: one addend vector and two multiplicand vectors. In every lane it takes the low 52 bits of each multiplicand as unsigned numbers and multiplies them into a 104-bit product. It then takes either the upper 52 bits of the product (bits 103:52) or the lower 52 bits (bits 51:0), widens that half with zeros to 64 bits, and adds it to the addend lane.

Each operation names its product half and its vector width: 128 bits, which is two lanes, or 256 bits, which is four lanes. Lanes above the chosen width come out as zero. Operations go in as a stream. Valid-in marks an operation, and the matching result comes out with valid-out three cycles later. A new operation can go in on every cycle.

Top module: `lane_mac52`

## Requirements
- R1: Bits 63:52 of every multiplicand lane have no effect on the result. Only bits 51:0 take part, as unsigned values.
- R2: With `in_hi` = 1, output lane j equals addend lane j plus the zero-extended product bits 103:52. That term is always below 2^52.
- R3: With `in_hi` = 0, output lane j equals addend lane j plus the zero-extended product bits 51:0.
- R4: The lane sum is taken modulo 2^64. A carry out of bit 63 is dropped, with no flag and no saturation.
- R5: Lane j occupies bits 64j+63 to 64j of every vector. Lanes are independent: no carry and no data crosses between lanes.
- R6: With `in_wide` = 0 (128-bit), only lanes 0 and 1 are computed and output bits 255:128 are zero. With `in_wide` = 1 (256-bit), all four lanes are computed.
- R7: `in_hi` and `in_wide` are captured with the operands on the valid-in cycle. The mode and width may change on every cycle without affecting operations already in flight.
- R8: `out_valid` is high exactly 3 cycles after `in_valid` was high. One operation is accepted per cycle, and results keep input order.
- R9: An asynchronous active-low reset clears all pipeline valid bits, so `out_valid` is 0 during and right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present on the inputs |
| in_hi | input | 1 | 1: accumulate product bits 103:52; 0: accumulate bits 51:0 |
| in_wide | input | 1 | 1: 256-bit, 4 lanes; 0: 128-bit, 2 lanes |
| in_acc | input | 256 | Addend vector, four 64-bit lanes |
| in_ma | input | 256 | First multiplicand vector |
| in_mb | input | 256 | Second multiplicand vector |
| out_valid | output | 1 | Result present on `out_data` |
| out_data | output | 256 | Result vector |

## Verification
The hardest cases to reach from the ports are three-way combinations: a product whose selected half is at its maximum, landing on an addend within a few counts of 2^64, while the multiplicand top bits carry junk that must be dropped. The stimulus builds these directly. It uses all-ones 52-bit multiplicands with all-ones upper garbage and addends just below 2^64, in both modes. It also walks a single set bit through every multiplicand position, so each product bit crosses the split at bit 52. A long pseudo-random stream then changes mode, width and valid on every cycle, so that operations with different settings sit in the pipeline together.

// File: rtl/lane_mac52.sv
module lane_mac52 #(
  parameter int LANES        = 4,
  parameter int LANE_W       = 64,
  parameter int MUL_W        = 52,
  parameter int NARROW_LANES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      in_hi,
  input  logic                      in_wide,
  input  logic [LANES*LANE_W-1:0]   in_acc,
  input  logic [LANES*LANE_W-1:0]   in_ma,
  input  logic [LANES*LANE_W-1:0]   in_mb,
  output logic                      out_valid,
  output logic [LANES*LANE_W-1:0]   out_data
);

  localparam int VW = LANES * LANE_W;
  localparam int PW = 2 * MUL_W;
  localparam int AW = LANES * MUL_W;
  localparam int PV = LANES * PW;

  logic          s1_v, s1_hi, s1_wide;
  logic [VW-1:0] s1_acc;
  logic [AW-1:0] s1_a, s1_b;
  logic          s2_v, s2_hi, s2_wide;
  logic [VW-1:0] s2_acc;
  logic [PV-1:0] s2_prod;

  logic [AW-1:0] a_trim, b_trim;
  logic [PV-1:0] prod;
  logic [VW-1:0] result;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [PW-1:0]     pa, pb;
    logic [MUL_W-1:0]  half;
    logic [LANE_W-1:0] sum;
    logic              unused_top;

    assign a_trim[j*MUL_W +: MUL_W] = in_ma[j*LANE_W +: MUL_W];
    assign b_trim[j*MUL_W +: MUL_W] = in_mb[j*LANE_W +: MUL_W];
    assign unused_top = ^{in_ma[j*LANE_W+MUL_W +: LANE_W-MUL_W],
                          in_mb[j*LANE_W+MUL_W +: LANE_W-MUL_W]};

    assign pa = {{MUL_W{1'b0}}, s1_a[j*MUL_W +: MUL_W]};
    assign pb = {{MUL_W{1'b0}}, s1_b[j*MUL_W +: MUL_W]};
    assign prod[j*PW +: PW] = pa * pb;

    assign half = s2_hi ? s2_prod[j*PW+MUL_W +: MUL_W] : s2_prod[j*PW +: MUL_W];
    assign sum  = s2_acc[j*LANE_W +: LANE_W] + {{(LANE_W-MUL_W){1'b0}}, half};

    if (j < NARROW_LANES) begin : g_base
      assign result[j*LANE_W +: LANE_W] = sum;
    end else begin : g_ext
      assign result[j*LANE_W +: LANE_W] = s2_wide ? sum : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v      <= 1'b0;
      s2_v      <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      s1_v      <= in_valid;
      s2_v      <= s1_v;
      out_valid <= s2_v;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_hi   <= in_hi;
      s1_wide <= in_wide;
      s1_acc  <= in_acc;
      s1_a    <= a_trim;
      s1_b    <= b_trim;
    end
    if (s1_v) begin
      s2_hi   <= s1_hi;
      s2_wide <= s1_wide;
      s2_acc  <= s1_acc;
      s2_prod <= prod;
    end
    if (s2_v) out_data <= result;
  end

endmodule

module lane_mac52_chk #(
  parameter int LANE_W = 64,
  parameter int MUL_W  = 52,
  parameter int UPPER  = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_wide,
  input logic [LANE_W-1:0] acc0,
  input logic              out_valid,
  input logic [LANE_W-1:0] out0,
  input logic [UPPER-1:0]  out_upper
);

  logic [1:0] warm_cnt;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_cnt <= '0;
    else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
  end
  assign warm = (warm_cnt == 2'd3);

  assert_reset_clears_R9: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  assert_fixed_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (out_valid == $past(in_valid, 3)));

  assert_narrow_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid && !$past(in_wide, 3)) |-> (out_upper == '0));

  assert_term_below_2pow52_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid) |-> ((out0 - $past(acc0, 3)) < (64'd1 << MUL_W)));

endmodule

bind lane_mac52 lane_mac52_chk #(
  .LANE_W(LANE_W), .MUL_W(MUL_W), .UPPER(VW - NARROW_LANES*LANE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_wide   (in_wide),
  .acc0      (in_acc[LANE_W-1:0]),
  .out_valid (out_valid),
  .out0      (out_data[LANE_W-1:0]),
  .out_upper (out_data[VW-1:NARROW_LANES*LANE_W])
);

// File: tb/lane_mac52_bench.sv
module lane_mac52_bench;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, in_hi = 1'b0, in_wide = 1'b0;
  logic [255:0] in_acc = '0, in_ma = '0, in_mb = '0;
  logic         out_valid;
  logic [255:0] out_data;

  int checks = 0;
  int errors = 0;

  logic         pv [3];
  logic [255:0] pe [3];
  string        pt [3];
  logic [63:0]  seed = 64'h9E37_79B9_7F4A_7C15;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_mac52 u_lane_mac52 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_hi(in_hi), .in_wide(in_wide),
    .in_acc(in_acc), .in_ma(in_ma), .in_mb(in_mb),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [63:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    return seed;
  endfunction

  function automatic logic [255:0] rvec();
    return {rnd(), rnd(), rnd(), rnd()};
  endfunction

  function automatic logic [255:0] model(input logic hi, input logic wide,
                                         input logic [255:0] acc, input logic [255:0] ma,
                                         input logic [255:0] mb);
    logic [255:0] r;
    logic [127:0] p;
    logic [63:0]  t;
    for (int j = 0; j < 4; j++) begin
      if (j >= 2 && !wide) begin
        r[j*64 +: 64] = 64'd0;
      end else begin
        p = {76'd0, ma[j*64 +: 52]} * {76'd0, mb[j*64 +: 52]};
        t = hi ? 64'(p >> 52) : 64'(p % (128'd1 << 52));
        r[j*64 +: 64] = acc[j*64 +: 64] + t;
      end
    end
    return r;
  endfunction

  task automatic check_out();
    checks++;
    if (out_valid !== pv[2]) begin
      errors++;
      $display("FAIL R8 out_valid actual=%b expected=%b", out_valid, pv[2]);
    end else if (pv[2]) begin
      checks++;
      if (out_data !== pe[2]) begin
        errors++;
        $display("FAIL %s out_data actual=%h expected=%h", pt[2], out_data, pe[2]);
      end
    end
  endtask

  task automatic step(input logic v, input logic hi, input logic wide,
                      input logic [255:0] acc, input logic [255:0] ma,
                      input logic [255:0] mb, input logic [255:0] exp_v, input string tag);
    @(negedge clk);
    check_out();
    pv[2] = pv[1]; pe[2] = pe[1]; pt[2] = pt[1];
    pv[1] = pv[0]; pe[1] = pe[0]; pt[1] = pt[0];
    pv[0] = v;     pe[0] = exp_v; pt[0] = tag;
    in_valid = v; in_hi = hi; in_wide = wide;
    in_acc = acc; in_ma = ma; in_mb = mb;
  endtask

  task automatic op(input logic hi, input logic wide, input logic [255:0] acc,
                    input logic [255:0] ma, input logic [255:0] mb, input string tag);
    step(1'b1, hi, wide, acc, ma, mb, model(hi, wide, acc, ma, mb), tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, '0, '0, '0, '0, "R8");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin pv[i] = 1'b0; pe[i] = '0; pt[i] = "R9"; end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
        errors++;
        $display("FAIL R9 out_valid in reset actual=%b expected=0", out_valid);
      end
    end
    rst_n = 1'b1;
  endtask

  localparam logic [63:0] ONES52 = 64'h000F_FFFF_FFFF_FFFF;
  localparam logic [63:0] ONES64 = 64'hFFFF_FFFF_FFFF_FFFF;

  initial begin
    for (int i = 0; i < 3; i++) begin pv[i] = 1'b0; pe[i] = '0; pt[i] = "R9"; end
    do_reset();
    idle(3);

    // R2 R3 R4: fixed hand-computed values for maximum product
    step(1'b1, 1'b1, 1'b1, {4{64'd0}}, {4{ONES52}}, {4{ONES52}},
         {4{64'h000F_FFFF_FFFF_FFFE}}, "R2");
    step(1'b1, 1'b0, 1'b1, {4{64'd5}}, {4{ONES52}}, {4{ONES52}},
         {4{64'd6}}, "R3");
    step(1'b1, 1'b0, 1'b1, {4{ONES64}}, {4{ONES52}}, {4{ONES52}},
         {4{64'd0}}, "R4");
    step(1'b1, 1'b1, 1'b1, {4{64'hFFFF_FFFF_FFFF_FFF0}}, {4{ONES52}}, {4{ONES52}},
         {4{64'h000F_FFFF_FFFF_FFEE}}, "R4");
    // R1: garbage in bits 63:52 of every multiplicand lane
    step(1'b1, 1'b1, 1'b1, {4{64'd0}}, {4{ONES64}}, {4{ONES64}},
         {4{64'h000F_FFFF_FFFF_FFFE}}, "R1");
    step(1'b1, 1'b0, 1'b1, {4{64'd0}}, {4{64'hFFF0_0000_0000_0000}}, {4{ONES64}},
         {4{64'd0}}, "R1");
    // R6: narrow op clears upper lanes even with nonzero operands there
    step(1'b1, 1'b0, 1'b0, {4{64'd7}}, {4{64'd3}}, {4{64'd4}},
         {64'd0, 64'd0, 64'd19, 64'd19}, "R6");
    // R5: one busy lane, neighbours must equal their addend
    step(1'b1, 1'b1, 1'b1, {64'd11, 64'd22, ONES64, 64'd44},
         {64'd0, 64'd0, ONES52, 64'd0}, {64'd0, 64'd0, ONES52, 64'd0},
         {64'd11, 64'd22, 64'h000F_FFFF_FFFF_FFFD, 64'd44}, "R5");
    idle(4);

    // R2 R3: walking bit across every multiplicand position, both modes
    for (int k = 0; k < 52; k++) begin
      for (int h = 0; h < 2; h++) begin
        logic [255:0] a, b;
        a = {4{64'd1 << k}} | {4{64'hABC0_0000_0000_0000}};
        b = rvec();
        op(h[0], 1'b1, rvec(), a, b, h[0] ? "R2" : "R3");
      end
    end

    // R4: addends within a few counts of 2^64
    for (int i = 0; i < 64; i++) begin
      logic [255:0] acc;
      acc = {4{ONES64 - 64'(i)}};
      op(i[0], i[1], acc, rvec() | {4{ONES52}} & rvec(), {4{ONES52}}, "R4");
    end

    // R7 R8: mode, width and valid change every cycle, with bubbles
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] r;
      r = rnd();
      if (r[0] | r[1])
        op(r[2], r[3], rvec(), rvec(), rvec(), "R7");
      else
        step(1'b0, r[2], r[3], rvec(), rvec(), rvec(), '0, "R8");
    end
    idle(4);

    // R9: reset while operations are in flight, then resume
    op(1'b1, 1'b1, rvec(), rvec(), rvec(), "R9");
    op(1'b0, 1'b0, rvec(), rvec(), rvec(), "R9");
    do_reset();
    idle(2);
    for (int i = 0; i < 8; i++) op(i[0], i[1], rvec(), rvec(), rvec(), "R8");
    idle(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule